// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block lets an external controller reach a small bank of 8-bit configuration and status registers over a four-wire SPI link running in mode 1 (clock idles low, data sampled on the falling clock edge). The chip-select, clock and data-in pins are brought into the system clock domain through synchronisers. Every SPI event is detected and acted on there, so the block has no logic clocked by the serial clock.

A frame opens with an 8-bit header, most significant bit first. The header holds a 2-bit operation code and a 6-bit register address. Data bytes follow. In a write, each complete byte goes to the next address in turn. In a read, the block streams register contents out in the same way. Two otherwise unused addresses act as command triggers. Writing the key byte 0x96 to address 0x3C restores every register to its reset value. Writing 0x96 to address 0x3D raises a one-cycle oscillator-calibration request. Status fields are fed in from surrounding logic and are read-only. A one-cycle strobe marks each moment the interrupt-status register is loaded for shift-out, so the interrupt logic can clear its request.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, address 0x00 reads 0x24, 0x01 reads 0x22, 0x02 reads 0x02|0xC0 (0xC2), the writable upper nibble of 0x03 is 0, and 0x08 reads 0x00; the cfg outputs show the same values.
- R2: While spi_csn is low, MOSI bits are taken on falling SCLK edges, most significant bit first. Header bits [7:6] are the operation (00 write or command, 01 read, 10/11 unused) and bits [5:0] are the start address. Raising spi_csn returns the frame logic to the header phase.
- R3: In a write, data byte k of the frame is stored at start address + k. The 6-bit address wraps from 0x3F to 0x00. A byte is committed on its eighth falling edge, and a partial byte cut off by spi_csn rising is discarded.
- R4: In a read, MISO carries the start-address register MSB first, starting after the eighth header edge, then the following addresses byte by byte (wrapping) for as long as clocks continue. Each bit changes only after a falling SCLK edge and holds until the next one.
- R5: spi_miso is high impedance whenever spi_csn is high.
- R6: Address 0x03[3:0] reads int_code_i. Address 0x04 reads energy_i[7:0], 0x05 reads energy_i[15:8], 0x06 reads {000, energy_i[20:16]}, 0x07 reads {00, distance_i}, 0x3A reads {trco_stat_i, 000000} and 0x3B reads {srco_stat_i, 000000}. Writes to these fields and to unmapped addresses have no effect, and unmapped addresses read 0.
- R7: Writing 0x96 to 0x3C reloads all registers with their reset values and pulses cmd_preset_o for exactly one cycle. Any other value written there does nothing.
- R8: Writing 0x96 to 0x3D pulses cmd_calib_o for exactly one cycle and leaves all registers unchanged. Any other value written there does nothing.
- R9: irq_rd_stb_o pulses for one cycle each time address 0x03 is loaded for shift-out, whether as the start address or reached within a burst, and at no other time.
- R10: A frame with operation 10 or 11 writes nothing, issues no strobe or command, and drives MISO to 0 for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller, high impedance while deselected |
| int_code_i | input | 4 | Interrupt cause shown at 0x03[3:0] |
| energy_i | input | 21 | Event energy shown at 0x04 to 0x06 |
| distance_i | input | 6 | Distance estimate shown at 0x07 |
| trco_stat_i | input | 2 | Slow-oscillator calibration status {done, failed} |
| srco_stat_i | input | 2 | Fast-oscillator calibration status {done, failed} |
| afe_cfg_o | output | 8 | Register 0x00 |
| thr_cfg_o | output | 8 | Register 0x01 |
| stat_cfg_o | output | 8 | Register 0x02 |
| int_cfg_o | output | 4 | Writable upper nibble of register 0x03 |
| tune_cfg_o | output | 8 | Register 0x08 |
| cmd_preset_o | output | 1 | One-cycle restore-defaults pulse |
| cmd_calib_o | output | 1 | One-cycle calibration request |
| irq_rd_stb_o | output | 1 | One-cycle strobe when 0x03 is loaded for shift-out |

## Verification
The embedded assertions cover the cycle-level rules. Synchronised SCLK falls never come back to back. Chip-select high clears the frame state. Commits only happen in a write frame with a complete header. Strobes and command pulses last one cycle. A restore pulse coincides with default contents. A calibration pulse and writes to read-only addresses leave the bank unchanged. Whole-frame behaviour needs the bench scenarios: byte ordering, address increment and wrap, the exact bit sequence on MISO, discarding of partial bytes, unused operations, and the number of interrupt strobes across a burst.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

  localparam int DW = 8;   // register and byte width
  localparam int AW = 6;   // register address width (header = 2 + AW bits = DW)

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_RSV2  = 2'b10,
    OP_RSV3  = 2'b11
  } spi_op_e;

  localparam int NUM_CFG = 5;
  localparam logic [AW-1:0] CFG_ADDR [NUM_CFG] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h08};
  localparam logic [DW-1:0] CFG_DFLT [NUM_CFG] = '{8'h24, 8'h22, 8'hC2, 8'h00, 8'h00};
  localparam logic [DW-1:0] CFG_MASK [NUM_CFG] = '{8'hFF, 8'hFF, 8'hFF, 8'hF0, 8'hFF};

  localparam logic [AW-1:0] ADDR_IRQ    = 6'h03;
  localparam logic [AW-1:0] ADDR_EN_LO  = 6'h04;
  localparam logic [AW-1:0] ADDR_EN_MID = 6'h05;
  localparam logic [AW-1:0] ADDR_EN_HI  = 6'h06;
  localparam logic [AW-1:0] ADDR_DIST   = 6'h07;
  localparam logic [AW-1:0] ADDR_TSTAT  = 6'h3A;
  localparam logic [AW-1:0] ADDR_SSTAT  = 6'h3B;
  localparam logic [AW-1:0] ADDR_PRESET = 6'h3C;
  localparam logic [AW-1:0] ADDR_CALIB  = 6'h3D;
  localparam logic [DW-1:0] CMD_KEY     = 8'h96;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sclk_fall_o,
  output logic csn_o,
  output logic mosi_o
);

  logic [STAGES-1:0] sclk_q, csn_q, mosi_q;
  logic              sclk_d_q;
  logic [STAGES-1:0] sclk_n, csn_n, mosi_n;

  always_comb begin
    sclk_n = {sclk_q[STAGES-2:0], sclk_i};
    csn_n  = {csn_q[STAGES-2:0],  csn_i};
    mosi_n = {mosi_q[STAGES-2:0], mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= '0;
      csn_q    <= '1;
      mosi_q   <= '0;
      sclk_d_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_n;
      csn_q    <= csn_n;
      mosi_q   <= mosi_n;
      sclk_d_q <= sclk_q[STAGES-1];
    end
  end

  assign sclk_fall_o = sclk_d_q & ~sclk_q[STAGES-1];
  assign csn_o       = csn_q[STAGES-1];
  assign mosi_o      = mosi_q[STAGES-1];

  // a detected fall cannot repeat on the next cycle (R2)
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall_o |=> !sclk_fall_o);

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_fall_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          irq_rd_stb_o,
  output logic          tx_bit_o
);

  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW-1);

  logic           hdr_done_q, hdr_done_n;
  logic [BCW-1:0] bit_cnt_q, bit_cnt_n;
  logic [DW-1:0]  rx_q, rx_n;
  logic [DW-1:0]  tx_q, tx_n;
  spi_op_e        op_q, op_n;
  logic [AW-1:0]  ptr_q, ptr_n;
  logic           wr_en_q, wr_en_n;
  logic [AW-1:0]  wr_addr_q, wr_addr_n;
  logic [DW-1:0]  wr_data_q, wr_data_n;
  logic           stb_q, stb_n;

  logic [DW-1:0]  rx_shift;
  logic           byte_end;
  spi_op_e        hdr_op;
  logic [AW-1:0]  hdr_addr;

  always_comb begin
    rx_shift  = {rx_q[DW-2:0], mosi_i};
    byte_end  = sclk_fall_i && (bit_cnt_q == LAST_BIT);
    hdr_op    = spi_op_e'(rx_shift[DW-1:DW-2]);
    hdr_addr  = rx_shift[AW-1:0];
    rd_addr_o = hdr_done_q ? ptr_q : hdr_addr;
  end

  always_comb begin
    hdr_done_n = hdr_done_q;
    bit_cnt_n  = bit_cnt_q;
    rx_n       = rx_q;
    tx_n       = tx_q;
    op_n       = op_q;
    ptr_n      = ptr_q;
    wr_en_n    = 1'b0;
    wr_addr_n  = wr_addr_q;
    wr_data_n  = wr_data_q;
    stb_n      = 1'b0;
    if (csn_i) begin
      hdr_done_n = 1'b0;
      bit_cnt_n  = '0;
      rx_n       = '0;
      tx_n       = '0;
      op_n       = OP_WRITE;
    end else if (sclk_fall_i) begin
      bit_cnt_n = bit_cnt_q + BCW'(1);
      rx_n      = rx_shift;
      if (!hdr_done_q) begin
        if (byte_end) begin
          hdr_done_n = 1'b1;
          op_n       = hdr_op;
          if (hdr_op == OP_READ) begin
            tx_n  = rd_data_i;
            ptr_n = hdr_addr + AW'(1);
            stb_n = (hdr_addr == ADDR_IRQ);
          end else begin
            ptr_n = hdr_addr;
          end
        end
      end else begin
        case (op_q)
          OP_WRITE: begin
            if (byte_end) begin
              wr_en_n   = 1'b1;
              wr_addr_n = ptr_q;
              wr_data_n = rx_shift;
              ptr_n     = ptr_q + AW'(1);
            end
          end
          OP_READ: begin
            if (byte_end) begin
              tx_n  = rd_data_i;
              ptr_n = ptr_q + AW'(1);
              stb_n = (ptr_q == ADDR_IRQ);
            end else begin
              tx_n = {tx_q[DW-2:0], 1'b0};
            end
          end
          default: tx_n = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_done_q <= 1'b0;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      op_q       <= OP_WRITE;
      ptr_q      <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      stb_q      <= 1'b0;
    end else begin
      hdr_done_q <= hdr_done_n;
      bit_cnt_q  <= bit_cnt_n;
      rx_q       <= rx_n;
      tx_q       <= tx_n;
      op_q       <= op_n;
      ptr_q      <= ptr_n;
      wr_en_q    <= wr_en_n;
      wr_addr_q  <= wr_addr_n;
      wr_data_q  <= wr_data_n;
      stb_q      <= stb_n;
    end
  end

  assign wr_en_o      = wr_en_q;
  assign wr_addr_o    = wr_addr_q;
  assign wr_data_o    = wr_data_q;
  assign irq_rd_stb_o = stb_q;
  assign tx_bit_o     = tx_q[DW-1];

  // deselect clears the frame back to the header phase (R2)
  assert_deselect_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csn_i |=> (!hdr_done_q && bit_cnt_q == '0));

  // commits only come from a write frame past its header (R3, R10)
  assert_commit_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (hdr_done_q && op_q == OP_WRITE));

  // interrupt strobe is one cycle wide and only inside a read frame (R9)
  assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (op_q == OP_READ) ##1 !stb_q);

  // unused operations keep MISO data at zero (R10)
  assert_rsv_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done_q && (op_q == OP_RSV2 || op_q == OP_RSV3)) |-> (tx_q == '0));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic [AW-1:0]              rd_addr_i,
  input  logic [3:0]                 int_code_i,
  input  logic [20:0]                energy_i,
  input  logic [5:0]                 distance_i,
  input  logic [1:0]                 trco_stat_i,
  input  logic [1:0]                 srco_stat_i,
  output logic [DW-1:0]              rd_data_o,
  output logic [NUM_CFG-1:0][DW-1:0] cfg_o,
  output logic                       cmd_preset_o,
  output logic                       cmd_calib_o
);

  logic preset_hit, calib_hit;
  logic preset_q, calib_q;

  always_comb begin
    preset_hit = wr_en_i && (wr_addr_i == ADDR_PRESET) && (wr_data_i == CMD_KEY);
    calib_hit  = wr_en_i && (wr_addr_i == ADDR_CALIB)  && (wr_data_i == CMD_KEY);
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    logic [DW-1:0] val_q, val_n;
    logic          load_en;
    always_comb begin
      load_en = preset_hit || (wr_en_i && wr_addr_i == CFG_ADDR[i]);
      val_n   = preset_hit ? (CFG_DFLT[i] & CFG_MASK[i]) : (wr_data_i & CFG_MASK[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= CFG_DFLT[i] & CFG_MASK[i];
      else if (load_en) val_q <= val_n;
    end
    assign cfg_o[i] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= 1'b0;
      calib_q  <= 1'b0;
    end else begin
      preset_q <= preset_hit;
      calib_q  <= calib_hit;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (rd_addr_i == CFG_ADDR[i]) rd_data_o = cfg_o[i];
    case (rd_addr_i)
      ADDR_IRQ:    rd_data_o = rd_data_o | {{(DW-4){1'b0}}, int_code_i};
      ADDR_EN_LO:  rd_data_o = energy_i[7:0];
      ADDR_EN_MID: rd_data_o = energy_i[15:8];
      ADDR_EN_HI:  rd_data_o = {3'b000, energy_i[20:16]};
      ADDR_DIST:   rd_data_o = {2'b00, distance_i};
      ADDR_TSTAT:  rd_data_o = {trco_stat_i, 6'b000000};
      ADDR_SSTAT:  rd_data_o = {srco_stat_i, 6'b000000};
      default:     ;
    endcase
  end

  assign cmd_preset_o = preset_q;
  assign cmd_calib_o  = calib_q;

  // restore pulse coincides with default contents (R7)
  assert_preset_dflt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_q |-> (cfg_o[0] == 8'h24 && cfg_o[1] == 8'h22 && cfg_o[2] == 8'hC2
                  && cfg_o[3] == 8'h00 && cfg_o[4] == 8'h00));

  assert_preset_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_q |=> !preset_q);

  // calibration request leaves the bank untouched and lasts one cycle (R8)
  assert_calib_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    calib_q |-> $stable(cfg_o));

  assert_calib_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    calib_q |=> !calib_q);

  // writes to read-only status addresses change nothing (R6)
  assert_ro_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_addr_i == ADDR_EN_LO || wr_addr_i == ADDR_EN_MID || wr_addr_i == ADDR_EN_HI
                 || wr_addr_i == ADDR_DIST || wr_addr_i == ADDR_TSTAT || wr_addr_i == ADDR_SSTAT))
    |=> $stable(cfg_o));

endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_regbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic [3:0]  int_code_i,
  input  logic [20:0] energy_i,
  input  logic [5:0]  distance_i,
  input  logic [1:0]  trco_stat_i,
  input  logic [1:0]  srco_stat_i,
  output logic [7:0]  afe_cfg_o,
  output logic [7:0]  thr_cfg_o,
  output logic [7:0]  stat_cfg_o,
  output logic [3:0]  int_cfg_o,
  output logic [7:0]  tune_cfg_o,
  output logic        cmd_preset_o,
  output logic        cmd_calib_o,
  output logic        irq_rd_stb_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                       sclk_fall, csn_s, mosi_s;
  logic [AW-1:0]              rd_addr, wr_addr;
  logic [DW-1:0]              rd_data, wr_data;
  logic                       wr_en, tx_bit;
  logic [NUM_CFG-1:0][DW-1:0] cfg;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_i(spi_sclk), .csn_i(spi_csn), .mosi_i(spi_mosi),
    .sclk_fall_o(sclk_fall), .csn_o(csn_s), .mosi_o(mosi_s)
  );

  spi_frame_ctrl frame_i (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_fall_i(sclk_fall), .csn_i(csn_s), .mosi_i(mosi_s),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .irq_rd_stb_o(irq_rd_stb_o), .tx_bit_o(tx_bit)
  );

  spi_reg_bank bank_i (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .int_code_i(int_code_i), .energy_i(energy_i), .distance_i(distance_i),
    .trco_stat_i(trco_stat_i), .srco_stat_i(srco_stat_i),
    .rd_data_o(rd_data), .cfg_o(cfg),
    .cmd_preset_o(cmd_preset_o), .cmd_calib_o(cmd_calib_o)
  );

  assign spi_miso   = spi_csn ? 1'bz : tx_bit;
  assign afe_cfg_o  = cfg[0];
  assign thr_cfg_o  = cfg[1];
  assign stat_cfg_o = cfg[2];
  assign int_cfg_o  = cfg[3][7:4];
  assign tune_cfg_o = cfg[4];

  // a restore and a calibration request never coincide (R7, R8)
  assert_cmd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cmd_preset_o && cmd_calib_o));

endmodule

// File: tb/spi_regbank_slave_tb.sv
module spi_regbank_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst_n, sclk, csn, mosi;
  wire  miso;
  logic [3:0]  int_code = 4'hA;
  logic [20:0] energy   = 21'h1BC35E;
  logic [5:0]  distance = 6'h2D;
  logic [1:0]  tstat    = 2'b10;
  logic [1:0]  sstat    = 2'b01;
  logic [7:0]  afe, thr, stc, tune;
  logic [3:0]  intc;
  logic        preset, calib, stb;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regbank_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi), .spi_miso(miso),
    .int_code_i(int_code), .energy_i(energy), .distance_i(distance),
    .trco_stat_i(tstat), .srco_stat_i(sstat),
    .afe_cfg_o(afe), .thr_cfg_o(thr), .stat_cfg_o(stc), .int_cfg_o(intc), .tune_cfg_o(tune),
    .cmd_preset_o(preset), .cmd_calib_o(calib), .irq_rd_stb_o(stb)
  );

  int n_chk = 0, n_fail = 0;
  int preset_cyc = 0, calib_cyc = 0, stb_cyc = 0;
  logic [7:0] tx_buf [0:69];
  logic [7:0] rx_buf [0:69];
  logic [7:0] mem_m  [0:63];
  logic       miso_nz;

  always @(negedge clk) begin
    if (preset) preset_cyc++;
    if (calib)  calib_cyc++;
    if (stb)    stb_cyc++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input int a);
    case (a)
      0, 1, 2, 8: mask_of = 8'hFF;
      3:          mask_of = 8'hF0;
      default:    mask_of = 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 64; a++) mem_m[a] = 8'h00;
    mem_m[0] = 8'h24; mem_m[1] = 8'h22; mem_m[2] = 8'hC2;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    if (a == 6'h3C && d == 8'h96) model_reset();
    else mem_m[a] = (mem_m[a] & ~mask_of(a)) | (d & mask_of(a));
  endtask

  function automatic logic [7:0] model_read(input int a);
    case (a)
      3:       model_read = mem_m[3] | {4'h0, int_code};
      4:       model_read = energy[7:0];
      5:       model_read = energy[15:8];
      6:       model_read = {3'b000, energy[20:16]};
      7:       model_read = {2'b00, distance};
      6'h3A:   model_read = {tstat, 6'b0};
      6'h3B:   model_read = {sstat, 6'b0};
      default: model_read = mem_m[a] & mask_of(a);
    endcase
  endfunction

  // runs nbytes whole bytes plus tail extra bits from tx_buf, capturing MISO
  task automatic frame(input int nbytes, input int tail);
    miso_nz = 1'b0;
    @(negedge clk); csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k <= nbytes; k++) begin
      for (int b = 7; b >= 0; b--) begin
        if (k == nbytes && (7 - b) >= tail) break;
        sclk = 1'b1; mosi = tx_buf[k][b];
        repeat (HALF) @(negedge clk);
        rx_buf[k][b] = miso;
        if (miso !== 1'b0 && k > 0) miso_nz = 1'b1;
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
      end
    end
    csn = 1'b1; mosi = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr1(input int a, input logic [7:0] d);
    tx_buf[0] = {2'b00, 6'(a)}; tx_buf[1] = d;
    frame(2, 0);
  endtask

  task automatic rd_burst(input int a, input int n);
    tx_buf[0] = {2'b01, 6'(a)};
    for (int k = 1; k <= n; k++) tx_buf[k] = 8'h00;
    frame(n + 1, 0);
  endtask

  task automatic check_reads(input int a, input int n, input string req);
    rd_burst(a, n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = model_read((a + k) % 64);
      check(rx_buf[k+1] === e, req, {24'h0, rx_buf[k+1]}, {24'h0, e});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    n_fail++;
    $display("FAIL watchdog expired actual %0d expected %0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0;
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values at the outputs, R5 idle MISO
    check(afe === 8'h24, "R1 afe", {24'h0, afe}, 32'h24);
    check(thr === 8'h22, "R1 thr", {24'h0, thr}, 32'h22);
    check(stc === 8'hC2, "R1 stat", {24'h0, stc}, 32'hC2);
    check(intc === 4'h0 && tune === 8'h00, "R1 int/tune", {20'h0, intc, tune}, 32'h0);
    check(miso === 1'bz, "R5 miso idle", {31'h0, miso === 1'bz}, 32'h1);

    // R1 R6 R4 R9: read 0x00..0x08 from reset in one burst, one strobe at 0x03
    s0 = stb_cyc;
    check_reads(0, 9, "R1 R4 reset burst read");
    check(stb_cyc == s0 + 1, "R9 strobe in burst", stb_cyc - s0, 1);
    check_reads(6'h3A, 2, "R6 calib status read");

    // R3 R6: single-byte writes to every address, then one full burst read
    for (int a = 0; a < 64; a++) begin
      logic [7:0] v;
      v = 8'((a * 37 + 11) & 8'hFF);
      wr1(a, v);
      model_write(a, v);
    end
    check(preset_cyc == 0 && calib_cyc == 0, "R7 R8 no stray command",
          preset_cyc + calib_cyc, 0);
    s0 = stb_cyc;
    check_reads(0, 64, "R3 R6 sweep single writes");
    check(stb_cyc == s0 + 1, "R9 strobe once per pass", stb_cyc - s0, 1);

    // R3: one long burst write over all addresses, checked by a wrapping read
    tx_buf[0] = {2'b00, 6'h00};
    for (int a = 0; a < 64; a++) begin
      tx_buf[a+1] = 8'(a) ^ 8'hC3;
      model_write(a, 8'(a) ^ 8'hC3);
    end
    frame(65, 0);
    check_reads(6'h3E, 12, "R3 R4 burst write wrap read");

    // R3: write burst wraps 0x3F -> 0x00
    tx_buf[0] = {2'b00, 6'h3F}; tx_buf[1] = 8'h11; tx_buf[2] = 8'h5B;
    frame(3, 0);
    model_write(6'h3F, 8'h11); model_write(0, 8'h5B);
    check(afe === 8'h5B, "R3 write wrap", {24'h0, afe}, 32'h5B);

    // R3: partial byte dropped on deselect
    tx_buf[0] = {2'b00, 6'h01}; tx_buf[1] = 8'hFF;
    frame(1, 5);
    check(thr === mem_m[1], "R3 partial byte", {24'h0, thr}, {24'h0, mem_m[1]});

    // R10: unused operations neither write nor drive nor strobe
    s0 = stb_cyc;
    tx_buf[0] = {2'b10, 6'h01}; tx_buf[1] = 8'hE7; tx_buf[2] = 8'h3C;
    frame(3, 0);
    check(thr === mem_m[1] && !miso_nz, "R10 op 10", {23'h0, miso_nz, thr}, {24'h0, mem_m[1]});
    tx_buf[0] = {2'b11, 6'h03}; tx_buf[1] = 8'h0F;
    frame(2, 0);
    check(!miso_nz && stb_cyc == s0, "R10 op 11", {31'h0, miso_nz}, 32'h0);
    check(intc === mem_m[3][7:4], "R10 op 11 no write", {28'h0, intc}, {28'h0, mem_m[3][7:4]});

    // R9: single read of 0x03 strobes, read of 0x04 does not
    s0 = stb_cyc;
    check_reads(3, 1, "R6 irq read");
    check(stb_cyc == s0 + 1, "R9 single read 03", stb_cyc - s0, 1);
    s0 = stb_cyc;
    check_reads(4, 2, "R6 energy read");
    check(stb_cyc == s0, "R9 no strobe 04", stb_cyc - s0, 0);

    // R8: key to 0x3D pulses calibration once, other value nothing
    wr1(6'h3D, 8'h95);
    check(calib_cyc == 0, "R8 wrong key", calib_cyc, 0);
    wr1(6'h3D, 8'h96);
    check(calib_cyc == 1 && preset_cyc == 0, "R8 calib pulse", calib_cyc, 1);
    check(afe === mem_m[0] && tune === mem_m[8], "R8 bank kept", {24'h0, afe}, {24'h0, mem_m[0]});

    // R7: wrong key to 0x3C does nothing, key restores defaults with one pulse
    wr1(6'h3C, 8'h69);
    check(preset_cyc == 0 && afe === mem_m[0], "R7 wrong key", preset_cyc, 0);
    wr1(6'h3C, 8'h96);
    model_write(6'h3C, 8'h96);
    check(preset_cyc == 1, "R7 preset pulse", preset_cyc, 1);
    check(afe === 8'h24 && thr === 8'h22 && stc === 8'hC2 && tune === 8'h00,
          "R7 defaults", {afe, thr, stc, tune}, 32'h2422C200);
    check_reads(0, 9, "R7 readback");

    // R5: deselected MISO after all traffic
    check(miso === 1'bz, "R5 miso after frames", {31'h0, miso === 1'bz}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule